// File: doc/BRIEF.md
# Eight-Stage Pipeline Operand Forwarding Unit

This block resolves read-after-write hazards for an in-order pipeline whose stages run fetch, predict/register-read (PR), decode (ID), execute (EX), memory-read (MR), memory-write (MW), write-back (WB) and a final forward-only stage (FW). Register values are read in PR, one stage before decode. By the time an instruction sits in ID, those values may already be stale. The unit keeps the source register numbers and operand values of the instructions in ID and EX. Each cycle it compares them with the destinations of the results held further down the pipe, and it replaces a stale operand with the newest matching result.

Decode takes corrected operands from all five later stages: the EX result, MR, MW, WB and FW. Execute takes them again from MR, MW and WB only. FW serves decode alone. A value corrected in ID is registered into EX with the instruction. If the producer an ID operand needs is a load still in EX with no data yet, the unit requests a stall. The ID instruction is then held, keeping any values it has already picked up, and a bubble enters EX. A load whose data is still missing in MR does not stall. Its value is collected by EX from MW one cycle later.

Top module: `fwd_unit`

## Requirements
- R1: Each ID operand takes the value of the youngest matching producer, with priority EX result (select code 1) over MR (2) over MW (3) over WB (4) over FW (5). With no match it takes the value read in PR (select code 0).
- R2: A producer matches only when its write-enable is high and its destination equals the source number. Source register 0 never matches and always passes the PR value.
- R3: One cycle after leaving ID, the EX operands equal the corrected ID operands. They are then replaced by a matching MR, MW or WB result, in that priority order. A matching FW result has no effect on EX operands.
- R4: `stall` is high in the same cycle as a valid ID instruction whose youngest matching producer for either operand is the EX stage with `exRdy` low.
- R5: While `stall` is high, the ID instruction is kept and the PR inputs are ignored. ID operands capture their forwarded values, so a producer that retires during the stall is not lost.
- R6: The cycle after a stall, `exValid` is low (a bubble). Otherwise `exValid` follows the validity of the instruction that left ID.
- R7: A youngest matching producer in MR with `mrRdy` low does not stall. One cycle later, EX takes that value from MW.
- R8: After reset, `exValid` and `stall` are low and the EX operands are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prValid | input | 1 | A valid instruction is in PR |
| prRsNum | input | REG_W | First source register number in PR |
| prRtNum | input | REG_W | Second source register number in PR |
| prRsVal | input | DATA_W | Register-file value for the first source |
| prRtVal | input | DATA_W | Register-file value for the second source |
| exWe | input | 1 | EX result will write a register |
| exDst | input | REG_W | EX destination register |
| exVal | input | DATA_W | EX result value |
| exRdy | input | 1 | EX result value is available (low for a load) |
| mrWe | input | 1 | MR result will write a register |
| mrDst | input | REG_W | MR destination register |
| mrVal | input | DATA_W | MR result value |
| mrRdy | input | 1 | MR result value is available |
| mwWe | input | 1 | MW result will write a register |
| mwDst | input | REG_W | MW destination register |
| mwVal | input | DATA_W | MW result value |
| wbWe | input | 1 | WB result will write a register |
| wbDst | input | REG_W | WB destination register |
| wbVal | input | DATA_W | WB result value |
| fwWe | input | 1 | FW result wrote a register |
| fwDst | input | REG_W | FW destination register |
| fwVal | input | DATA_W | FW result value |
| idOpA | output | DATA_W | Corrected first operand of the ID instruction |
| idOpB | output | DATA_W | Corrected second operand of the ID instruction |
| exOpA | output | DATA_W | Corrected first operand of the EX instruction |
| exOpB | output | DATA_W | Corrected second operand of the EX instruction |
| stall | output | 1 | Hold PR and ID, insert a bubble into EX |
| exValid | output | 1 | The EX operands belong to a valid instruction |

## Verification
The hardest case to reach is a stall during which the other operand's only producer sits in FW. That producer retires before the stall ends, and on the following cycle the stalling load is in MR with data still missing. The stimulus sets up exactly this. It makes the first source match an EX load with `exRdy` low while FW writes the second source, and it offers a new instruction in PR. In the next cycle the load moves to MR with `mrRdy` low and FW goes idle. The checks confirm that the second operand kept the FW value, that a bubble entered EX, and that EX later took the load value from MW.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Number of result-holding stages that can feed decode: EX, MR, MW, WB, FW.
  localparam int unsigned NUM_PROD = 5;

  // Operand source select. Codes 1..5 follow pipeline order, youngest first.
  typedef enum logic [2:0] {
    SEL_REG = 3'd0,
    SEL_EX  = 3'd1,
    SEL_MR  = 3'd2,
    SEL_MW  = 3'd3,
    SEL_WB  = 3'd4,
    SEL_FW  = 3'd5
  } fwdSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    fwdSel_e idSelA;
    fwdSel_e idSelB;
    fwdSel_e exSelA;
    fwdSel_e exSelB;
    logic    idHold;
    logic    exLoad;
  } fwdCtrl_t;

endpackage

// File: rtl/fwd_pick.sv
// Finds the youngest producer whose destination matches one source number.
// Index 0 is the youngest producer.
module fwd_pick #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned AW   = 5,
  localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [AW-1:0]            srcNum,
  input  logic [NSRC-1:0]          prodWe,
  input  logic [NSRC-1:0][AW-1:0]  prodDst,
  input  logic [NSRC-1:0]          prodRdy,
  output logic                     hit,
  output logic [IW-1:0]            idx,
  output logic                     idxRdy
);

  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    idxRdy = 1'b1;
    // Walk from oldest to youngest; the last match written wins.
    for (int i = NSRC - 1; i >= 0; i--) begin
      if ((srcNum != '0) && prodWe[i] && (prodDst[i] == srcNum)) begin
        hit    = 1'b1;
        idx    = IW'(i);
        idxRdy = prodRdy[i];
      end
    end
  end

endmodule

// File: rtl/fwd_ctrl.sv
// Control half: tracks register numbers and valid bits of ID and EX,
// computes the operand selects and the load-use stall.
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          prValid,
  input  logic [AW-1:0]                 prRsNum,
  input  logic [AW-1:0]                 prRtNum,
  input  logic [NUM_PROD-1:0]           prodWe,
  input  logic [NUM_PROD-1:0][AW-1:0]   prodDst,
  input  logic [NUM_PROD-1:0]           prodRdy,
  output fwdCtrl_t                      ctl,
  output logic                          stall,
  output logic                          exValid
);

  localparam int unsigned NUM_EX_PROD = 3; // MR, MW, WB
  localparam int unsigned ID_IW = $clog2(NUM_PROD);
  localparam int unsigned EX_IW = $clog2(NUM_EX_PROD);

  logic                 idValid;
  logic [1:0][AW-1:0]   idSrc;
  logic [1:0][AW-1:0]   exSrc;

  logic [1:0]             idHit, idRdy, opStall;
  logic [1:0][ID_IW-1:0]  idIdx;
  logic [1:0]             exHit, exRdy;
  logic [1:0][EX_IW-1:0]  exIdx;
  fwdSel_e [1:0]          idSel, exSel;

  for (genvar g = 0; g < 2; g++) begin : gOp
    fwd_pick #(.NSRC(NUM_PROD), .AW(AW)) uIdPick (
      .srcNum (idSrc[g]),
      .prodWe (prodWe),
      .prodDst(prodDst),
      .prodRdy(prodRdy),
      .hit    (idHit[g]),
      .idx    (idIdx[g]),
      .idxRdy (idRdy[g])
    );

    fwd_pick #(.NSRC(NUM_EX_PROD), .AW(AW)) uExPick (
      .srcNum (exSrc[g]),
      .prodWe (prodWe[3:1]),
      .prodDst(prodDst[3:1]),
      .prodRdy(prodRdy[3:1]),
      .hit    (exHit[g]),
      .idx    (exIdx[g]),
      .idxRdy (exRdy[g])
    );

    assign idSel[g] = idHit[g] ? fwdSel_e'(3'(idIdx[g]) + 3'd1) : SEL_REG;
    assign exSel[g] = exHit[g] ? fwdSel_e'(3'(exIdx[g]) + 3'd2) : SEL_REG;

    // Only a not-yet-ready EX producer forces a stall; an MR one is caught in EX.
    assign opStall[g] = idHit[g] && (idIdx[g] == '0) && !idRdy[g];

    // EX never sees a producer whose value is still missing.
    AST_EX_READY: assert property (@(posedge clk) disable iff (!rstN)
      (exValid && exHit[g]) |-> exRdy[g]); // R7
  end

  assign stall = idValid && (|opStall);

  always_comb begin
    ctl.idSelA = idSel[0];
    ctl.idSelB = idSel[1];
    ctl.exSelA = exSel[0];
    ctl.exSelB = exSel[1];
    ctl.idHold = stall;
    ctl.exLoad = !stall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idValid <= 1'b0;
      idSrc   <= '0;
      exSrc   <= '0;
      exValid <= 1'b0;
    end else if (stall) begin
      exValid <= 1'b0;
    end else begin
      idValid  <= prValid;
      idSrc[0] <= prRsNum;
      idSrc[1] <= prRtNum;
      exSrc    <= idSrc;
      exValid  <= idValid;
    end
  end

  AST_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !exValid); // R6

  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (idValid && (idSrc == $past(idSrc)))); // R5

  AST_EX_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> (exValid == $past(idValid))); // R6

endmodule

// File: rtl/fwd_dpath.sv
// Datapath half: operand registers of ID and EX and the select muxes.
module fwd_dpath
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fwdCtrl_t                      ctl,
  input  logic [DW-1:0]                 prRsVal,
  input  logic [DW-1:0]                 prRtVal,
  input  logic [NUM_PROD-1:0][DW-1:0]   prodVal,
  output logic [DW-1:0]                 idOpA,
  output logic [DW-1:0]                 idOpB,
  output logic [DW-1:0]                 exOpA,
  output logic [DW-1:0]                 exOpB
);

  function automatic logic [DW-1:0] pickVal(
    input fwdSel_e                        sel,
    input logic [DW-1:0]                  base,
    input logic [NUM_PROD-1:0][DW-1:0]    pv
  );
    case (sel)
      SEL_EX:  return pv[0];
      SEL_MR:  return pv[1];
      SEL_MW:  return pv[2];
      SEL_WB:  return pv[3];
      SEL_FW:  return pv[4];
      default: return base;
    endcase
  endfunction

  logic [1:0][DW-1:0] prVal, idReg, exReg, idOp, exOp;
  fwdSel_e [1:0]      idSel, exSel;

  assign prVal[0] = prRsVal;
  assign prVal[1] = prRtVal;
  assign idSel[0] = ctl.idSelA;
  assign idSel[1] = ctl.idSelB;
  assign exSel[0] = ctl.exSelA;
  assign exSel[1] = ctl.exSelB;

  for (genvar g = 0; g < 2; g++) begin : gOp
    assign idOp[g] = pickVal(idSel[g], idReg[g], prodVal);
    assign exOp[g] = pickVal(exSel[g], exReg[g], prodVal);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idReg[g] <= '0;
        exReg[g] <= '0;
      end else begin
        // On a stall, ID keeps its instruction but latches forwarded values.
        idReg[g] <= ctl.idHold ? idOp[g] : prVal[g];
        if (ctl.exLoad) exReg[g] <= idOp[g];
      end
    end

    AST_EX_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      ctl.exLoad |=> (exReg[g] == $past(idOp[g]))); // R3

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      ctl.idHold |=> (idReg[g] == $past(idOp[g]))); // R5
  end

  assign idOpA = idOp[0];
  assign idOpB = idOp[1];
  assign exOpA = exOp[0];
  assign exOpB = exOp[1];

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prValid,
  input  logic [REG_W-1:0]  prRsNum,
  input  logic [REG_W-1:0]  prRtNum,
  input  logic [DATA_W-1:0] prRsVal,
  input  logic [DATA_W-1:0] prRtVal,
  input  logic              exWe,
  input  logic [REG_W-1:0]  exDst,
  input  logic [DATA_W-1:0] exVal,
  input  logic              exRdy,
  input  logic              mrWe,
  input  logic [REG_W-1:0]  mrDst,
  input  logic [DATA_W-1:0] mrVal,
  input  logic              mrRdy,
  input  logic              mwWe,
  input  logic [REG_W-1:0]  mwDst,
  input  logic [DATA_W-1:0] mwVal,
  input  logic              wbWe,
  input  logic [REG_W-1:0]  wbDst,
  input  logic [DATA_W-1:0] wbVal,
  input  logic              fwWe,
  input  logic [REG_W-1:0]  fwDst,
  input  logic [DATA_W-1:0] fwVal,
  output logic [DATA_W-1:0] idOpA,
  output logic [DATA_W-1:0] idOpB,
  output logic [DATA_W-1:0] exOpA,
  output logic [DATA_W-1:0] exOpB,
  output logic              stall,
  output logic              exValid
);

  logic [NUM_PROD-1:0]              prodWe;
  logic [NUM_PROD-1:0][REG_W-1:0]   prodDst;
  logic [NUM_PROD-1:0][DATA_W-1:0]  prodVal;
  logic [NUM_PROD-1:0]              prodRdy;
  fwdCtrl_t                         ctl;

  // Index 0 is the youngest producer. Values from MW onward are always present.
  assign prodWe  = {fwWe, wbWe, mwWe, mrWe, exWe};
  assign prodDst = {fwDst, wbDst, mwDst, mrDst, exDst};
  assign prodVal = {fwVal, wbVal, mwVal, mrVal, exVal};
  assign prodRdy = {3'b111, mrRdy, exRdy};

  fwd_ctrl #(.AW(REG_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .prValid(prValid),
    .prRsNum(prRsNum),
    .prRtNum(prRtNum),
    .prodWe (prodWe),
    .prodDst(prodDst),
    .prodRdy(prodRdy),
    .ctl    (ctl),
    .stall  (stall),
    .exValid(exValid)
  );

  fwd_dpath #(.DW(DATA_W)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .prRsVal(prRsVal),
    .prRtVal(prRtVal),
    .prodVal(prodVal),
    .idOpA  (idOpA),
    .idOpB  (idOpB),
    .exOpA  (exOpA),
    .exOpB  (exOpB)
  );

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        prValid = 1'b0;
  logic [4:0]  prRsNum = '0, prRtNum = '0;
  logic [31:0] prRsVal = '0, prRtVal = '0;
  logic        exWe = 0, mrWe = 0, mwWe = 0, wbWe = 0, fwWe = 0;
  logic [4:0]  exDst = '0, mrDst = '0, mwDst = '0, wbDst = '0, fwDst = '0;
  logic [31:0] exVal = '0, mrVal = '0, mwVal = '0, wbVal = '0, fwVal = '0;
  logic        exRdy = 1'b1, mrRdy = 1'b1;
  logic [31:0] idOpA, idOpB, exOpA, exOpB;
  logic        stall, exValid;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  fwd_unit uut (.*);

  // Vector: sources, producer destinations, write-enables {EX,MR,MW,WB,FW},
  // expected select code per operand (0 PR, 1 EX, 2 MR, 3 MW, 4 WB, 5 FW).
  typedef struct packed {
    logic [4:0] rs, rt, dEx, dMr, dMw, dWb, dFw;
    logic [4:0] we;
    logic [2:0] expA, expB;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd0,  5'd0, 5'd0,  5'd0,  5'd0,  5'b00000, 3'd0, 3'd0},
    '{5'd3,  5'd4,  5'd3,  5'd0, 5'd0,  5'd0,  5'd0,  5'b10000, 3'd1, 3'd0},
    '{5'd3,  5'd4,  5'd0,  5'd4, 5'd0,  5'd0,  5'd0,  5'b01000, 3'd0, 3'd2},
    '{5'd5,  5'd5,  5'd0,  5'd0, 5'd5,  5'd5,  5'd5,  5'b00111, 3'd3, 3'd3},
    '{5'd6,  5'd7,  5'd0,  5'd0, 5'd0,  5'd6,  5'd7,  5'b00011, 3'd4, 3'd5},
    '{5'd8,  5'd8,  5'd8,  5'd8, 5'd0,  5'd0,  5'd0,  5'b01000, 3'd2, 3'd2},
    '{5'd0,  5'd0,  5'd0,  5'd0, 5'd0,  5'd0,  5'd0,  5'b11111, 3'd0, 3'd0},
    '{5'd9,  5'd10, 5'd10, 5'd9, 5'd9,  5'd10, 5'd9,  5'b11111, 3'd2, 3'd1},
    '{5'd11, 5'd12, 5'd0,  5'd0, 5'd11, 5'd12, 5'd11, 5'b00111, 3'd3, 3'd4},
    '{5'd31, 5'd1,  5'd31, 5'd1, 5'd0,  5'd0,  5'd0,  5'b11000, 3'd1, 3'd2}
  };

  function automatic logic [31:0] rawA(input logic [4:0] n); return 32'h1000_0000 | 32'(n); endfunction
  function automatic logic [31:0] rawB(input logic [4:0] n); return 32'h2000_0000 | 32'(n); endfunction
  function automatic logic [31:0] prodV(input int code, input logic [4:0] d);
    return 32'hA000_0000 | (32'(code) << 16) | 32'(d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    exWe = 0; mrWe = 0; mwWe = 0; wbWe = 0; fwWe = 0;
    exRdy = 1; mrRdy = 1;
  endtask

  task automatic setProd(input vec_t v);
    exDst = v.dEx; mrDst = v.dMr; mwDst = v.dMw; wbDst = v.dWb; fwDst = v.dFw;
    {exWe, mrWe, mwWe, wbWe, fwWe} = v.we;
    exVal = prodV(1, v.dEx); mrVal = prodV(2, v.dMr); mwVal = prodV(3, v.dMw);
    wbVal = prodV(4, v.dWb); fwVal = prodV(5, v.dFw);
  endtask

  task automatic offer(input logic [4:0] rs, input logic [4:0] rt);
    prValid = 1; prRsNum = rs; prRtNum = rt; prRsVal = rawA(rs); prRtVal = rawB(rt);
  endtask

  function automatic logic [31:0] expVal(input vec_t v, input logic [2:0] code, input bit isB);
    logic [4:0] s;
    s = isB ? v.rt : v.rs;
    case (code)
      3'd0: return isB ? rawB(s) : rawA(s);
      3'd1: return prodV(1, v.dEx);
      3'd2: return prodV(2, v.dMr);
      3'd3: return prodV(3, v.dMw);
      3'd4: return prodV(4, v.dWb);
      default: return prodV(5, v.dFw);
    endcase
  endfunction

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #2;
    chk("R8 exValid", 32'(exValid), 0);
    chk("R8 stall", 32'(stall), 0);
    chk("R8 exOpA", exOpA, 0);

    // Table walk: R1/R2 on ID, then R3 capture into EX
    for (int k = 0; k < NV; k++) begin
      @(posedge clk); #1; idle(); offer(VECS[k].rs, VECS[k].rt);
      @(posedge clk); #1; prValid = 0; setProd(VECS[k]);
      #2;
      chk("R1 R2 idOpA", idOpA, expVal(VECS[k], VECS[k].expA, 0));
      chk("R1 R2 idOpB", idOpB, expVal(VECS[k], VECS[k].expB, 1));
      chk("R4 no stall", 32'(stall), 0);
      @(posedge clk); #1; idle();
      #2;
      chk("R3 exOpA captured", exOpA, expVal(VECS[k], VECS[k].expA, 0));
      chk("R3 exOpB captured", exOpB, expVal(VECS[k], VECS[k].expB, 1));
      chk("R6 exValid", 32'(exValid), 1);
    end

    // Load-use stall, capture during stall, MR-not-ready pickup in EX
    @(posedge clk); #1; idle(); offer(5'd3, 5'd4);
    @(posedge clk); #1;
    offer(5'd20, 5'd21);
    exWe = 1; exDst = 5'd3; exRdy = 0; exVal = 32'hDEAD_0001;
    fwWe = 1; fwDst = 5'd4; fwVal = 32'hF00D_0004;
    #2;
    chk("R4 stall raised", 32'(stall), 1);
    @(posedge clk); #1;
    prValid = 0; idle();
    mrWe = 1; mrDst = 5'd3; mrRdy = 0; mrVal = 32'hDEAD_0002;
    #2;
    chk("R6 bubble", 32'(exValid), 0);
    chk("R7 no stall on MR", 32'(stall), 0);
    chk("R5 held value", idOpB, 32'hF00D_0004);
    @(posedge clk); #1; idle();
    mwWe = 1; mwDst = 5'd3; mwVal = 32'hCAFE_0003;
    #2;
    chk("R7 EX from MW", exOpA, 32'hCAFE_0003);
    chk("R5 EX got captured", exOpB, 32'hF00D_0004);
    chk("R6 exValid after stall", 32'(exValid), 1);
    chk("R5 PR taken after stall", idOpA, rawA(5'd20));

    // EX-stage forwarding priorities and FW exclusion
    @(posedge clk); #1; idle(); offer(5'd13, 5'd14);
    @(posedge clk); #1; prValid = 0;
    @(posedge clk); #1;
    mrWe = 1; mrDst = 5'd13; mrVal = prodV(2, 5'd13);
    wbWe = 1; wbDst = 5'd14; wbVal = prodV(4, 5'd14);
    fwWe = 1; fwDst = 5'd13; fwVal = prodV(5, 5'd13);
    #2;
    chk("R3 EX MR first", exOpA, prodV(2, 5'd13));
    chk("R3 EX WB", exOpB, prodV(4, 5'd14));
    mrWe = 0;
    mwWe = 1; mwDst = 5'd13; mwVal = prodV(3, 5'd13);
    wbDst = 5'd13; wbVal = prodV(4, 5'd13);
    fwDst = 5'd14; fwVal = prodV(5, 5'd14);
    #1;
    chk("R3 EX MW over WB", exOpA, prodV(3, 5'd13));
    chk("R3 EX ignores FW", exOpB, rawB(5'd14));
    mwWe = 0;
    #1;
    chk("R3 EX WB only", exOpA, prodV(4, 5'd13));
    idle();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule